// File: doc/BRIEF.md
# Matrix Keypad Scanner and Classifier

This block scans a key matrix of five row lines and four column lines. It drives exactly one active-high column strobe at a time and samples the row lines on every clock. While no key is being tracked, the strobe steps to the next column each cycle. A row line that goes high while a column is strobed marks a contact at that row/column crossing.

A contact becomes a key press only when the same single row has been seen on the frozen column for a run of consecutive samples. This is a digital debounce. On acceptance the block registers a 4-bit key value and a 2-bit class code, and raises a halt flag. The halt flag stays high, and the strobe stays on the pressed column, for the whole time the key is held. The press ends only after the held row has read low for the same number of consecutive samples. Scanning then resumes at the next column.

The downstream controller uses the class code to tell a digit from an arithmetic operator or the equals key. It uses the halt flag to act exactly once per press.

Top module: `keypad_scanner`

## Requirements
- R1: After a synchronous reset the column strobe is 4'b0001, halt is 0, the key value is 0 and the key class is 2'b00. This applies also when reset is raised in the middle of a press.
- R2: While no contact is being tracked, exactly one strobe bit is high. The active bit moves 0, 1, 2, 3, 0 one step per clock.
- R3: A press is accepted only after 4 consecutive samples show the same single row high on the strobed column. Halt rises in the cycle after the 4th such sample. A contact lasting only 3 samples is discarded and scanning continues.
- R4: A key at row r (0 to 3) and column c reports value r*4+c with class 2'b00 (digit).
- R5: Row 4 at columns 0, 1 and 2 reports class 2'b01 (operator) with value 0 (add), 1 (subtract) or 2 (multiply) respectively.
- R6: Row 4 at column 3 reports class 2'b10 (equals) with value 0.
- R7: While halt is high, the strobe, the key value and the key class do not change. A second row going high on the same column is ignored.
- R8: Halt falls only after the held row has read low for 4 consecutive samples, and a shorter low gap is ignored. In the cycle halt falls, the strobe moves to the next column (column 3 wraps to column 0).
- R9: When more than one row is high on the strobed column, no press is accepted and scanning continues.
- R10: After halt falls, the key value and class keep the last accepted press until a new one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_i | input | 5 | Row sense lines, high when a key connects the strobed column |
| col_strobe_o | output | 4 | One-hot active-high column strobes |
| key_value_o | output | 4 | Value of the last accepted key (digit or operation code) |
| key_type_o | output | 2 | Class of the last accepted key: 00 digit, 01 operator, 10 equals |
| halt_o | output | 1 | High for the whole duration of an accepted press |

## Verification
Two functions can fall in the same cycle: the end of a press, where the fourth low sample drops halt, and the advance of the column strobe. The bench releases a key and reads both halt and the strobe at the sample point right after the fourth low sample. It expects halt low and the strobe already on the following column, and one cycle earlier it expects halt still high on the old column. A second overlap is a further row rising on the held column while halt is high. That case is judged by the value, class and halt staying unchanged across it.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  typedef enum logic [1:0] {
    KEY_DIGIT = 2'b00,
    KEY_OPER  = 2'b01,
    KEY_EQUAL = 2'b10
  } key_class_e;

  typedef enum logic [1:0] {
    TRK_SCAN    = 2'b00,
    TRK_CONFIRM = 2'b01,
    TRK_HELD    = 2'b10
  } trk_state_e;

endpackage

// File: rtl/kp_col_sequencer.sv
module kp_col_sequencer #(
  parameter int NUM_COLS = 4,
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance_i,
  output logic [NUM_COLS-1:0] strobe_o,
  output logic [COL_W-1:0]    col_idx_o
);

  logic [NUM_COLS-1:0] strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= {{(NUM_COLS-1){1'b0}}, 1'b1};
    end else if (advance_i) begin
      strobe_q <= {strobe_q[NUM_COLS-2:0], strobe_q[NUM_COLS-1]};
    end
  end

  always_comb begin
    col_idx_o = '0;
    for (int i = 0; i < NUM_COLS; i++) begin
      if (strobe_q[i]) col_idx_o = COL_W'(i);
    end
  end

  assign strobe_o = strobe_q;

  // R2: exactly one strobe active at all times out of reset
  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe_q) == 1);

  // R2: without advance the strobe holds, with advance it moves
  assert_strobe_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(advance_i) && !$past(rst) |-> $stable(strobe_q));

endmodule

// File: rtl/kp_keymap.sv
module kp_keymap
  import keypad_pkg::*;
#(
  parameter int NUM_ROWS = 5,
  parameter int NUM_COLS = 4,
  parameter int VAL_W    = 4,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic [ROW_W-1:0] row_idx_i,
  input  logic [COL_W-1:0] col_idx_i,
  output logic [VAL_W-1:0] value_o,
  output key_class_e       kind_o
);

  localparam int LAST_ROW = NUM_ROWS - 1;
  localparam int LAST_COL = NUM_COLS - 1;

  always_comb begin
    if (int'(row_idx_i) < LAST_ROW) begin
      value_o = VAL_W'(int'(row_idx_i) * NUM_COLS + int'(col_idx_i));
      kind_o  = KEY_DIGIT;
    end else if (int'(col_idx_i) < LAST_COL) begin
      value_o = VAL_W'(col_idx_i);
      kind_o  = KEY_OPER;
    end else begin
      value_o = '0;
      kind_o  = KEY_EQUAL;
    end
  end

endmodule

// File: rtl/kp_press_tracker.sv
module kp_press_tracker
  import keypad_pkg::*;
#(
  parameter int NUM_ROWS = 5,
  parameter int DEBOUNCE = 4,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int CNT_W = (DEBOUNCE > 2) ? $clog2(DEBOUNCE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] rows_i,
  output logic                advance_o,
  output logic                accept_o,
  output logic                halt_o,
  output logic [ROW_W-1:0]    row_idx_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE - 1);

  trk_state_e          state_q, state_d;
  logic [NUM_ROWS-1:0] row_q, row_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                single_hit;
  logic                held_low;

  assign single_hit = (rows_i != '0) && ((rows_i & (rows_i - NUM_ROWS'(1))) == '0);
  assign held_low   = (rows_i & row_q) == '0;

  always_comb begin
    state_d   = state_q;
    row_d     = row_q;
    cnt_d     = cnt_q;
    advance_o = 1'b0;
    accept_o  = 1'b0;
    unique case (state_q)
      TRK_SCAN: begin
        if (single_hit) begin
          state_d = TRK_CONFIRM;
          row_d   = rows_i;
          cnt_d   = CNT_W'(1);
        end else begin
          advance_o = 1'b1;
        end
      end
      TRK_CONFIRM: begin
        if (rows_i == row_q) begin
          if (cnt_q == CNT_LAST) begin
            state_d  = TRK_HELD;
            cnt_d    = '0;
            accept_o = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end else begin
          state_d   = TRK_SCAN;
          cnt_d     = '0;
          advance_o = 1'b1;
        end
      end
      TRK_HELD: begin
        if (held_low) begin
          if (cnt_q == CNT_LAST) begin
            state_d   = TRK_SCAN;
            cnt_d     = '0;
            advance_o = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end else begin
          cnt_d = '0;
        end
      end
      default: begin
        state_d = TRK_SCAN;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_SCAN;
      row_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    row_idx_o = '0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (row_q[i]) row_idx_o = ROW_W'(i);
    end
  end

  assign halt_o = (state_q == TRK_HELD);

  // R3: a press is only entered on a cycle that saw a row high
  assert_halt_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_o) |-> $past(rows_i != '0));

  // R8: a press only ends after a sample with the held row low
  assert_halt_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(halt_o) |-> $past((rows_i & row_q) == '0));

  // R9: several rows together never start a press from idle
  assert_multi_row_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_SCAN) && ($countones(rows_i) > 1) |=> (state_q == TRK_SCAN));

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import keypad_pkg::*;
#(
  parameter int NUM_ROWS = 5,
  parameter int NUM_COLS = 4,
  parameter int VAL_W    = 4,
  parameter int DEBOUNCE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] row_i,
  output logic [NUM_COLS-1:0] col_strobe_o,
  output logic [VAL_W-1:0]    key_value_o,
  output logic [1:0]          key_type_o,
  output logic                halt_o
);

  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int COL_W = $clog2(NUM_COLS);

  logic             advance;
  logic             accept;
  logic [ROW_W-1:0] row_idx;
  logic [COL_W-1:0] col_idx;
  logic [VAL_W-1:0] map_value;
  key_class_e       map_kind;
  logic [VAL_W-1:0] value_q;
  key_class_e       kind_q;

  kp_col_sequencer #(.NUM_COLS(NUM_COLS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .advance_i (advance),
    .strobe_o  (col_strobe_o),
    .col_idx_o (col_idx)
  );

  kp_press_tracker #(.NUM_ROWS(NUM_ROWS), .DEBOUNCE(DEBOUNCE)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .rows_i    (row_i),
    .advance_o (advance),
    .accept_o  (accept),
    .halt_o    (halt_o),
    .row_idx_o (row_idx)
  );

  kp_keymap #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .VAL_W(VAL_W)) u_map (
    .row_idx_i (row_idx),
    .col_idx_i (col_idx),
    .value_o   (map_value),
    .kind_o    (map_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      kind_q  <= KEY_DIGIT;
    end else if (accept) begin
      value_q <= map_value;
      kind_q  <= map_kind;
    end
  end

  assign key_value_o = value_q;
  assign key_type_o  = kind_q;

  // R7: strobe and reported key frozen across a held press
  assert_press_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    halt_o && $past(halt_o) |-> $stable(col_strobe_o) && $stable(key_value_o) && $stable(key_type_o));

  // R5: an operator class always carries a legal operation code
  assert_op_code_R5: assert property (@(posedge clk) disable iff (rst)
    (key_type_o == KEY_OPER) |-> (int'(key_value_o) < NUM_COLS - 1));

  // R6: the unused class code never appears
  assert_class_legal_R6: assert property (@(posedge clk) disable iff (rst)
    key_type_o != 2'b11);

endmodule

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  // {row[2:0], col[1:0], value[3:0], class[1:0]}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {3'd0, 2'd0, 4'd0,  2'd0}, {3'd0, 2'd1, 4'd1,  2'd0},
    {3'd0, 2'd2, 4'd2,  2'd0}, {3'd0, 2'd3, 4'd3,  2'd0},
    {3'd1, 2'd0, 4'd4,  2'd0}, {3'd1, 2'd1, 4'd5,  2'd0},
    {3'd1, 2'd2, 4'd6,  2'd0}, {3'd1, 2'd3, 4'd7,  2'd0},
    {3'd2, 2'd0, 4'd8,  2'd0}, {3'd2, 2'd1, 4'd9,  2'd0},
    {3'd2, 2'd2, 4'd10, 2'd0}, {3'd2, 2'd3, 4'd11, 2'd0},
    {3'd3, 2'd0, 4'd12, 2'd0}, {3'd3, 2'd1, 4'd13, 2'd0},
    {3'd3, 2'd2, 4'd14, 2'd0}, {3'd3, 2'd3, 4'd15, 2'd0},
    {3'd4, 2'd0, 4'd0,  2'd1}, {3'd4, 2'd1, 4'd1,  2'd1},
    {3'd4, 2'd2, 4'd2,  2'd1}, {3'd4, 2'd3, 4'd0,  2'd2}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rows;
  logic [3:0] strobe;
  logic [3:0] kval;
  logic [1:0] ktype;
  logic       halt;
  logic [19:0] keys_down = '0;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  keypad_scanner u_keypad_scanner (
    .clk          (clk),
    .rst          (rst),
    .row_i        (rows),
    .col_strobe_o (strobe),
    .key_value_o  (kval),
    .key_type_o   (ktype),
    .halt_o       (halt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    rows = '0;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 4; c++)
        if (keys_down[r*4+c] && strobe[c]) rows[r] = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic wait_col(input int c);
    for (int k = 0; k < 8 && strobe != (4'b1 << c); k++) @(negedge clk);
    chk(strobe == (4'b1 << c), "R2 reach column", int'(strobe), 1 << c);
  endtask

  task automatic press(input int r, input int c);
    wait_col(c);
    keys_down[r*4+c] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strobe == 4'b0001, "R1 strobe", int'(strobe), 1);
    chk(halt == 1'b0, "R1 halt", int'(halt), 0);
    chk(kval == 4'd0 && ktype == 2'd0, "R1 key", int'({ktype, kval}), 0);
    rst = 1'b0;

    // R2: free-running scan
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk(strobe == (4'b1 << (i % 4)), "R2 rotate", int'(strobe), 1 << (i % 4));
    end

    // R4 R5 R6 keymap table, with R7 R8 R10 on each press
    for (int v = 0; v < NV; v++) begin
      automatic int r   = int'(VEC[v][10:8]);
      automatic int c   = int'(VEC[v][7:6]);
      automatic int ev  = int'(VEC[v][5:2]);
      automatic int et  = int'(VEC[v][1:0]);
      automatic string tg = (et == 0) ? "R4" : (et == 1) ? "R5" : "R6";
      press(r, c);
      chk(halt == 1'b1, "R3 accept after 4 samples", int'(halt), 1);
      chk(int'(kval) == ev, {tg, " value"}, int'(kval), ev);
      chk(int'(ktype) == et, {tg, " class"}, int'(ktype), et);
      repeat (2) @(negedge clk);
      chk(strobe == (4'b1 << c), "R7 strobe frozen", int'(strobe), 1 << c);
      keys_down = '0;
      repeat (3) @(negedge clk);
      chk(halt == 1'b1, "R8 halt held over 3 low samples", int'(halt), 1);
      @(negedge clk);
      chk(halt == 1'b0, "R8 halt falls on 4th low sample", int'(halt), 0);
      chk(strobe == (4'b1 << ((c + 1) % 4)), "R8 next column", int'(strobe), 1 << ((c + 1) % 4));
      chk(int'(kval) == ev && int'(ktype) == et, "R10 key kept", int'({ktype, kval}), (et << 4) | ev);
    end

    // R3: 3-sample contact is discarded
    begin
      automatic bit seen = 1'b0;
      wait_col(2);
      keys_down[1*4+2] = 1'b1;
      repeat (3) @(negedge clk);
      keys_down = '0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (halt) seen = 1'b1;
      end
      chk(!seen, "R3 short contact ignored", int'(seen), 0);
      chk(int'(kval) == 0 && int'(ktype) == 2, "R3 key unchanged", int'({ktype, kval}), 32);
    end

    // R8: short release gap ignored
    begin
      automatic bit dropped = 1'b0;
      press(0, 1);
      chk(halt == 1'b1 && kval == 4'd1, "R8 setup press", int'(kval), 1);
      keys_down = '0;
      repeat (2) @(negedge clk);
      keys_down[0*4+1] = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!halt) dropped = 1'b1;
      end
      chk(!dropped, "R8 short gap ignored", int'(dropped), 0);
      keys_down = '0;
      repeat (5) @(negedge clk);
      chk(halt == 1'b0, "R8 released", int'(halt), 0);
    end

    // R7: second row on held column ignored
    begin
      automatic bit bad = 1'b0;
      press(2, 1);
      chk(halt == 1'b1 && kval == 4'd9, "R7 setup press", int'(kval), 9);
      keys_down[0*4+1] = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!halt || kval != 4'd9 || ktype != 2'd0) bad = 1'b1;
      end
      chk(!bad, "R7 second key ignored", int'(kval), 9);
      keys_down = '0;
      repeat (4) @(negedge clk);
      chk(halt == 1'b0, "R7 release after both", int'(halt), 0);
    end

    // R9: two rows on one column
    begin
      automatic bit seen = 1'b0;
      automatic bit moved = 1'b0;
      keys_down[0*4+3] = 1'b1;
      keys_down[3*4+3] = 1'b1;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (halt) seen = 1'b1;
        if (strobe == 4'b1000) begin
          @(negedge clk);
          if (strobe != 4'b1000) moved = 1'b1;
        end
      end
      chk(!seen, "R9 no press on multi-row", int'(seen), 0);
      chk(moved, "R9 scan continues", int'(moved), 1);
      keys_down = '0;
      repeat (2) @(negedge clk);
    end

    // R1: reset in the middle of a press
    press(4, 2);
    chk(halt == 1'b1 && kval == 4'd2 && ktype == 2'd1, "R5 multiply before reset", int'(kval), 2);
    keys_down = '0;
    rst = 1'b1;
    @(negedge clk);
    chk(halt == 1'b0, "R1 mid-press halt", int'(halt), 0);
    chk(strobe == 4'b0001, "R1 mid-press strobe", int'(strobe), 1);
    chk(kval == 4'd0 && ktype == 2'd0, "R1 mid-press key", int'({ktype, kval}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finish_run();
  end

endmodule